// File: doc/BRIEF.md
# Prescaled 16-bit Up-Counter with Control Register

This block is a 16-bit up-counter that runs at a clock rate set by a prescaler. A byte-addressed register bus reaches the counter and one control register. The prescaler divides the clock by 2^n, with n from a 3-bit select input, to make the count tick. The same prescaler also gives a fixed tick every 64 running cycles, which feeds an external pulse accumulator.

The control register holds three live bits:
- a run enable,
- a stop-in-wait option, which freezes the timer while the wait input is high and drops the enable outputs for the accumulator and the modulus counter,
- a bit that can be written only once after reset.

Software can load the counter only while the test-mode input is high. A load does not restart the prescaler. Each wrap from 0xFFFF to 0x0000 gives a one-cycle overflow pulse.

Top module: `tick_timer16`

## Requirements
- R1: After reset the counter, the control register and the prescaler are all zero, so every read returns 0, and `ovfPulse` and `pacTick` are low.
- R2: Let n be `prescSel`. While the timer runs, the counter goes up by one on each cycle whose prescaler value has its low n bits all ones. A byte read at 0x4 returns the high byte in `busRdata[7:0]`. A byte read at 0x5 returns the low byte. A word read (`busWord`=1) at 0x4 returns all 16 bits.
- R3: Control bit 7 is the enable. While it is 0, the counter and the prescaler both hold and `pacTick` stays low.
- R4: The timer runs when bit 7 is 1 and it is not the case that both control bit 6 and `waitMode` are 1. `pacEn` and `mdcEn` are high exactly while the timer runs.
- R5: The first byte write to offset 0x6 after reset sets control bit 3 from `busWdata[3]`. Later writes leave bit 3 unchanged but still update bits 7 and 6.
- R6: A read of 0x6 returns bits 7, 6 and 3 with every other bit zero. Reads of any other offset return zero. Word writes to 0x6 have no effect.
- R7: The counter can be written only when `testMode`=1:
  - a byte write at 0x4 loads the high byte from `busWdata[7:0]`,
  - a byte write at 0x5 loads the low byte,
  - a word write at 0x4 loads all 16 bits.

  With `testMode`=0 these writes leave the counter unchanged. A write takes priority over a tick in the same cycle.
- R8: A counter write does not touch the prescaler, so the first tick after a load can come sooner than a full prescaler period.
- R9: `pacTick` is high for one cycle whenever the timer runs and the low 6 bits of the prescaler are all ones. This is once every 64 running cycles.
- R10: `ovfPulse` is high for the one cycle after a tick moves the counter from 0xFFFF to 0x0000. A write that loads 0 does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, qualified by busSel |
| busWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| busAddr | input | 4 | Byte offset |
| busWdata | input | 16 | Write data (bytes use bits 7:0) |
| busRdata | output | 16 | Read data for busAddr, combinational |
| testMode | input | 1 | Allows counter writes |
| waitMode | input | 1 | Wait state of the host |
| prescSel | input | 3 | Count divide select, ratio 2^n |
| pacTick | output | 1 | Divide-by-64 tick for the pulse accumulator |
| pacEn | output | 1 | Pulse accumulator enable |
| mdcEn | output | 1 | Modulus counter enable |
| ovfPulse | output | 1 | One-cycle wrap pulse |

## Verification
The hardest state to reach from the ports is a wrap at a slow prescale ratio, with a load landing part of the way through a prescaler period. Directed steps load 0xFFF0 in test mode at ratio 8 and then run until the overflow pulse appears. A cycle-accurate bench model predicts the shortened first period. Random traffic runs alongside and mixes loads with enable, wait and write-once changes. Reads are checked every cycle, so an ignored write shows up at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h6;

  typedef struct packed {
    logic             run;
    logic             wrHi;
    logic             wrLo;
    logic [CNT_W-1:0] data;
    logic [SEL_W-1:0] presc;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int PRE_W   = 7,
  parameter int PAC_LOG = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  output logic [CNT_W-1:0] cnt,
  output logic             pacTick,
  output logic             ovfPulse
);
  localparam int HALF = CNT_W / 2;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] preMask;
  logic             cntTick;
  logic             anyWr;

  always_comb begin
    preMask = PRE_W'((32'd1 << stb.presc) - 32'd1);
    cntTick = stb.run && ((pre & preMask) == preMask);
    pacTick = stb.run && (pre[PAC_LOG-1:0] == '1);
    anyWr   = stb.wrHi || stb.wrLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre      <= '0;
      cnt      <= '0;
      ovfPulse <= 1'b0;
    end else begin
      if (stb.run) pre <= pre + 1'b1;
      if (anyWr) begin
        if (stb.wrHi) cnt[CNT_W-1:HALF] <= stb.data[CNT_W-1:HALF];
        if (stb.wrLo) cnt[HALF-1:0]     <= stb.data[HALF-1:0];
      end else if (cntTick) begin
        cnt <= cnt + 1'b1;
      end
      ovfPulse <= cntTick && !anyWr && (cnt == '1);
    end
  end

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !anyWr) |=> $stable(cnt)) else $error("halt");          // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && !anyWr) |=> (cnt == $past(cnt) + 1'b1)) else $error("step"); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (cnt == '0)) else $error("wrap");                        // R10
  AST_PAC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |-> !pacTick) else $error("pac");                            // R9
  AST_PRE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && stb.run) |=> (pre == $past(pre) + 1'b1)) else $error("pre"); // R8
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              testMode,
  input  logic              waitMode,
  input  logic [SEL_W-1:0]  prescSel,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  busRdata,
  output tmrStrobe_t        stb,
  output logic              runOut
);
  logic ctrlEn, ctrlWaitStop, lockBit, onceDone;
  logic wrCtrl, wrCnt, run;

  always_comb begin
    wrCtrl = busSel && busWr && !busWord && (busAddr == OFS_CTRL);
    wrCnt  = busSel && busWr && testMode;
    run    = ctrlEn && !(ctrlWaitStop && waitMode);

    stb.run   = run;
    stb.presc = prescSel;
    stb.wrHi  = wrCnt && (busAddr == OFS_CNT_HI);
    stb.wrLo  = wrCnt && ((busWord && busAddr == OFS_CNT_HI) ||
                          (!busWord && busAddr == OFS_CNT_LO));
    stb.data  = busWord ? busWdata : {busWdata[7:0], busWdata[7:0]};
    runOut    = run;

    busRdata = '0;
    if (busWord) begin
      if (busAddr == OFS_CNT_HI) busRdata = cnt;
    end else begin
      case (busAddr)
        OFS_CNT_HI: busRdata[7:0] = cnt[CNT_W-1:8];
        OFS_CNT_LO: busRdata[7:0] = cnt[7:0];
        OFS_CTRL:   busRdata[7:0] = {ctrlEn, ctrlWaitStop, 2'b00, lockBit, 3'b000};
        default:    busRdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn       <= 1'b0;
      ctrlWaitStop <= 1'b0;
      lockBit      <= 1'b0;
      onceDone     <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEn       <= busWdata[7];
      ctrlWaitStop <= busWdata[6];
      onceDone     <= 1'b1;
      if (!onceDone) lockBit <= busWdata[3];
    end
  end

  AST_ONCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && onceDone) |=> $stable(lockBit)) else $error("once");     // R5
  AST_TEST_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> !(stb.wrHi || stb.wrLo)) else $error("test");         // R7
  AST_WAIT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (waitMode && ctrlWaitStop) |-> !runOut) else $error("wait");        // R4
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic        busWord,
  input  logic [3:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  input  logic        testMode,
  input  logic        waitMode,
  input  logic [2:0]  prescSel,
  output logic        pacTick,
  output logic        pacEn,
  output logic        mdcEn,
  output logic        ovfPulse
);
  tmrStrobe_t       stb;
  logic [CNT_W-1:0] cnt;
  logic             runOut;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWord(busWord),
    .busAddr(busAddr), .busWdata(busWdata), .testMode(testMode),
    .waitMode(waitMode), .prescSel(prescSel), .cnt(cnt),
    .busRdata(busRdata), .stb(stb), .runOut(runOut)
  );

  tmr_datapath #(.PRE_W(7), .PAC_LOG(6)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt(cnt),
    .pacTick(pacTick), .ovfPulse(ovfPulse)
  );

  assign pacEn = runOut;
  assign mdcEn = runOut;
endmodule

// File: tb/tb_tick_timer16.sv
module tb_tick_timer16;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWr = 0, busWord = 0;
  logic [3:0] busAddr = 0;
  logic [15:0] busWdata = 0, busRdata;
  logic testMode = 0, waitMode = 0;
  logic [2:0] prescSel = 0;
  logic pacTick, pacEn, mdcEn, ovfPulse;

  int nChk = 0, nBad = 0;
  logic [6:0] mPre = 0;
  logic [15:0] mCnt = 0;
  logic mEn = 0, mWs = 0, mLock = 0, mOnce = 0, mOvf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer16 dut (.*);

  function automatic logic mRun();
    return mEn && !(mWs && waitMode);
  endfunction

  function automatic logic [15:0] expRead();
    if (busWord) return (busAddr == 4'h4) ? mCnt : 16'h0;
    case (busAddr)
      4'h4: return {8'h0, mCnt[15:8]};
      4'h5: return {8'h0, mCnt[7:0]};
      4'h6: return {8'h0, mEn, mWs, 2'b00, mLock, 3'b000};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model update at the active edge, from the requirements
  task automatic modelEdge();
    logic [6:0] msk;
    logic tick, wHi, wLo;
    msk  = 7'((32'd1 << prescSel) - 1);
    tick = mRun() && ((mPre & msk) == msk);
    wHi  = busSel && busWr && testMode && busAddr == 4'h4;
    wLo  = busSel && busWr && testMode &&
           ((busWord && busAddr == 4'h4) || (!busWord && busAddr == 4'h5));
    mOvf = tick && !wHi && !wLo && mCnt == 16'hFFFF;
    if (mRun()) mPre = mPre + 1;
    if (wHi || wLo) begin
      if (wHi) mCnt[15:8] = busWord ? busWdata[15:8] : busWdata[7:0];
      if (wLo) mCnt[7:0]  = busWdata[7:0];
    end else if (tick) mCnt = mCnt + 1;
    if (busSel && busWr && !busWord && busAddr == 4'h6) begin
      mEn = busWdata[7]; mWs = busWdata[6];
      if (!mOnce) mLock = busWdata[3];
      mOnce = 1;
    end
  endtask

  // drive at negedge, check combinational and registered outputs, take edge
  task automatic cyc(logic s, logic w, logic wd, logic [3:0] a, logic [15:0] d,
                     logic tm, logic wt, logic [2:0] ps, string req);
    @(negedge clk);
    busSel = s; busWr = w; busWord = wd; busAddr = a; busWdata = d;
    testMode = tm; waitMode = wt; prescSel = ps;
    #1;
    chk({req, "/R2 read"}, busRdata, expRead());
    chk("R9 pacTick", {15'h0, pacTick}, {15'h0, mRun() && mPre[5:0] == 6'h3F});
    chk("R4 pacEn", {14'h0, pacEn, mdcEn}, {14'h0, mRun(), mRun()});
    chk("R10 ovfPulse", {15'h0, ovfPulse}, {15'h0, mOvf});
    @(posedge clk);
    modelEdge();
  endtask

  task automatic rd(logic wd, logic [3:0] a, logic tm, logic wt, logic [2:0] ps, string req);
    cyc(0, 0, wd, a, 16'h0, tm, wt, ps, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++; nChk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 2);
    @(negedge clk);
    #1;
    chk("R1 reset read cnt", busRdata, 16'h0);
    chk("R1 reset ovf/pac", {14'h0, ovfPulse, pacTick}, 16'h0);
    rstN = 1;
    rd(0, 4'h6, 0, 0, 0, "R1 ctrl");
    rd(1, 4'h4, 0, 0, 0, "R3 disabled hold");
    // R7: normal-mode counter write ignored
    cyc(1, 1, 1, 4'h4, 16'hBEEF, 0, 0, 0, "R7 normal write");
    rd(1, 4'h4, 0, 0, 0, "R7 ignored");
    chk("R7 normal write ignored", busRdata, 16'h0);
    // R5: first ctrl write sets lock bit, enables
    cyc(1, 1, 0, 4'h6, 16'h00C8, 0, 0, 0, "R5 first");
    rd(0, 4'h6, 0, 0, 0, "R5 readback");
    chk("R6/R5 ctrl value", busRdata, 16'h00C8);
    cyc(1, 1, 0, 4'h6, 16'h00B7, 0, 0, 0, "R5 second");
    rd(0, 4'h6, 0, 0, 0, "R5 held");
    chk("R5 lock held, R6 masked", busRdata, 16'h0088);
    cyc(1, 1, 1, 4'h6, 16'h0000, 0, 0, 0, "R6 word ctrl ignored");
    rd(0, 4'h6, 0, 0, 0, "R6");
    chk("R6 word write ignored", busRdata, 16'h0088);
    // R8/R10: load near wrap at ratio 8 mid-period
    for (int i = 0; i < 5; i++) rd(1, 4'h4, 0, 0, 3'd3, "R2 run");
    cyc(1, 1, 1, 4'h4, 16'hFFF0, 1, 0, 3'd3, "R8 load");
    cyc(1, 1, 0, 4'h5, 16'h00FC, 1, 0, 3'd3, "R7 lo byte");
    rd(1, 4'h4, 0, 0, 3'd3, "R7 after lo");
    chk("R7 low byte load", busRdata, mCnt);
    for (int i = 0; i < 60; i++) rd(1, 4'h4, 0, 0, 3'd3, "R10 wrap");
    // R4: stop in wait
    cyc(1, 1, 0, 4'h6, 16'h00C0, 0, 0, 0, "R4 set");
    for (int i = 0; i < 8; i++) rd(1, 4'h4, 0, 1, 0, "R4 wait halt");
    // R3: disable
    cyc(1, 1, 0, 4'h6, 16'h0000, 0, 0, 0, "R3 off");
    for (int i = 0; i < 70; i++) rd(1, 4'h4, 0, 0, 0, "R3 off hold");
    // random traffic
    for (int i = 0; i < 20000; i++) begin
      logic [3:0] a;
      logic [15:0] d;
      a = 4'(4 + $urandom_range(0, 3));
      d = 16'($urandom);
      if ($urandom_range(0, 3) != 0) d[7] = 1'b1;
      cyc($urandom_range(0, 5) == 0, 1'b1, $urandom_range(0, 3) == 0, a, d,
          1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0,
          3'($urandom_range(0, 2)), "R2 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule